// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB panel. Running on the pixel clock, it keeps a horizontal position counted in pixel clocks and a vertical position counted in whole lines. It decodes those positions into horizontal sync, vertical sync and data-enable. Each of the three outputs has its own selectable active level. The block also outputs a one-cycle strobe when vertical blanking begins, and a 24-bit colour that carries the background colour inside the active window when no layer is supplying pixels.

Every timing boundary is a cumulative position that ends a region, written as a running sum minus one. For each axis there are four such positions: the last position of sync, of sync plus back porch, of sync plus back porch plus active, and of the whole period. Because the counters are compared directly against these thresholds, no adders are needed at run time. A global enable starts the raster from the origin and, when dropped, parks it there.

Top module: `lcd_sync_gen`

## Requirements
- R1: While reset is high and on the cycle after it, both counters read 0, hsync, vsync and de sit at their inactive levels, vblank is 0 and rgb is 0 (black).
- R2: While enable is low, the counters are forced to 0 and hsync, vsync, de and vblank stay inactive.
- R3: On the first enabled cycle the counters show the origin (0,0). After that, h_cnt rises by one per clock and returns to 0 on the clock after it equals h_total_last.
- R4: v_cnt changes only when h_cnt wraps. It then rises by one, or returns to 0 if it equals v_total_last.
- R5: The hsync condition is active exactly when h_cnt <= h_sync_last. The vsync condition is active exactly when v_cnt <= v_sync_last.
- R6: The de condition is active exactly when h_porch_last < h_cnt <= h_active_last and v_porch_last < v_cnt <= v_active_last.
- R7: A polarity select of 1 drives its output high when the condition is active. A select of 0 drives the output low when active. This applies independently to hsync, vsync and de.
- R8: pclk_fall is the inverse of pclk_rise_sel, registered one cycle. A value of 1 asks the pad logic to launch data on the falling edge.
- R9: vblank is high for exactly one cycle, the cycle in which h_cnt = 0 and v_cnt = v_active_last + 1.
- R10: rgb carries bg_color when the de condition is active and layer_active is low. Otherwise rgb is 0. Red sits in bits [23:16], green in [15:8] and blue in [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global raster enable |
| hs_act_high | input | 1 | hsync active level (1 = high) |
| vs_act_high | input | 1 | vsync active level (1 = high) |
| de_act_high | input | 1 | de active level (1 = high) |
| pclk_rise_sel | input | 1 | 1 = launch data on rising pixel clock edge |
| h_sync_last | input | W | Last horizontal sync position |
| h_porch_last | input | W | Last horizontal back-porch position (cumulative) |
| h_active_last | input | W | Last horizontal active position (cumulative) |
| h_total_last | input | W | Last horizontal position of the line |
| v_sync_last | input | W | Last vertical sync line |
| v_porch_last | input | W | Last vertical back-porch line (cumulative) |
| v_active_last | input | W | Last vertical active line (cumulative) |
| v_total_last | input | W | Last line of the frame |
| layer_active | input | 1 | A pixel layer covers the current position |
| bg_color | input | 24 | Background colour {red, green, blue} |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk_fall | output | 1 | Pixel clock edge select for the pad |
| h_cnt | output | W | Current horizontal position |
| v_cnt | output | W | Current vertical line |
| vblank | output | 1 | One-cycle strobe at the start of vertical blanking |
| rgb | output | 24 | Background colour output |

## Verification
The bench uses three directed timing sets. The first is a mid-sized raster with every polarity high. The second is the same raster with every polarity low, which isolates the polarity stage from the window decode. The third gives every region a width of one, which puts the sync, porch and active comparisons on adjacent counts and exposes off-by-one errors at each boundary. Random timing sets with random polarities, background colours and per-cycle layer activity follow, and some of them drop enable in mid-frame to exercise the restart from the origin. Every cycle, each output is compared against a reference raster that the bench advances from the same inputs.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] blue;
    } rgb_t;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic de;
        logic vblank;
    } sync_flags_t;

    localparam rgb_t RGB_BLACK = '0;

    // Map an active/inactive condition to a pin level.
    function automatic logic drive_level(input logic active, input logic active_high);
        return active_high ? active : ~active;
    endfunction

endpackage

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         wrap
);

    always_comb begin
        wrap = step && (cnt_q >= last);
        if (clear) begin
            cnt_d = '0;
        end else if (wrap) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lcd_axis_window.sv
module lcd_axis_window #(
    parameter int W = 12
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] sync_last,
    input  logic [W-1:0] porch_last,
    input  logic [W-1:0] active_last,
    output logic         in_sync,
    output logic         in_active
);

    always_comb begin
        in_sync   = (pos <= sync_last);
        in_active = (pos > porch_last) && (pos <= active_last);
    end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             hs_act_high,
    input  logic             vs_act_high,
    input  logic             de_act_high,
    input  logic             pclk_rise_sel,
    input  logic [W-1:0]     h_sync_last,
    input  logic [W-1:0]     h_porch_last,
    input  logic [W-1:0]     h_active_last,
    input  logic [W-1:0]     h_total_last,
    input  logic [W-1:0]     v_sync_last,
    input  logic [W-1:0]     v_porch_last,
    input  logic [W-1:0]     v_active_last,
    input  logic [W-1:0]     v_total_last,
    input  logic             layer_active,
    input  logic [RGB_W-1:0] bg_color,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             pclk_fall,
    output logic [W-1:0]     h_cnt,
    output logic [W-1:0]     v_cnt,
    output logic             vblank,
    output logic [RGB_W-1:0] rgb
);

    localparam int NPIN = 3;

    logic         run_q;
    logic         restart;
    logic [W-1:0] h_d, v_d;
    logic         h_wrap, v_wrap;
    logic         h_sync_in, h_act_in, v_sync_in, v_act_in;
    sync_flags_t  flags_d;
    rgb_t         rgb_d;
    rgb_t         bg;
    logic [W:0]   blank_line;

    assign restart = !enable || !run_q;
    assign bg      = rgb_t'(bg_color);

    lcd_axis_ctr #(.W(W)) u_hctr (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .step  (1'b1),
        .last  (h_total_last),
        .cnt_q (h_cnt),
        .cnt_d (h_d),
        .wrap  (h_wrap)
    );

    lcd_axis_ctr #(.W(W)) u_vctr (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .step  (h_wrap),
        .last  (v_total_last),
        .cnt_q (v_cnt),
        .cnt_d (v_d),
        .wrap  (v_wrap)
    );

    lcd_axis_window #(.W(W)) u_hwin (
        .pos         (h_d),
        .sync_last   (h_sync_last),
        .porch_last  (h_porch_last),
        .active_last (h_active_last),
        .in_sync     (h_sync_in),
        .in_active   (h_act_in)
    );

    lcd_axis_window #(.W(W)) u_vwin (
        .pos         (v_d),
        .sync_last   (v_sync_last),
        .porch_last  (v_porch_last),
        .active_last (v_active_last),
        .in_sync     (v_sync_in),
        .in_active   (v_act_in)
    );

    // Decode on the next-state position so flags line up with the counters.
    always_comb begin
        blank_line     = {1'b0, v_active_last} + (W+1)'(1);
        flags_d.hsync  = enable && h_sync_in;
        flags_d.vsync  = enable && v_sync_in;
        flags_d.de     = enable && h_act_in && v_act_in;
        flags_d.vblank = enable && (h_d == '0) && ({1'b0, v_d} == blank_line);
        rgb_d          = (flags_d.de && !layer_active) ? bg : RGB_BLACK;
    end

    logic [NPIN-1:0] pin_act;
    logic [NPIN-1:0] pin_pol;
    logic [NPIN-1:0] pin_q;

    assign pin_act = {flags_d.de, flags_d.vsync, flags_d.hsync};
    assign pin_pol = {de_act_high, vs_act_high, hs_act_high};

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                pin_q[gi] <= drive_level(1'b0, pin_pol[gi]);
            end else begin
                pin_q[gi] <= drive_level(pin_act[gi], pin_pol[gi]);
            end
        end
    end

    assign hsync = pin_q[0];
    assign vsync = pin_q[1];
    assign de    = pin_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            vblank    <= 1'b0;
            rgb       <= RGB_BLACK;
            pclk_fall <= ~pclk_rise_sel;
        end else begin
            run_q     <= enable;
            vblank    <= flags_d.vblank;
            rgb       <= rgb_d;
            pclk_fall <= ~pclk_rise_sel;
        end
    end

    logic unused_ok;
    assign unused_ok = v_wrap;

endmodule

// File: rtl/lcd_sync_checker.sv
module lcd_sync_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         enable,
    input logic [W-1:0] h_cnt,
    input logic [W-1:0] v_cnt,
    input logic [W-1:0] h_total_last,
    input logic [W-1:0] v_total_last,
    input logic         vblank
);

    logic prev_en;

    always_ff @(posedge clk) begin
        if (rst) prev_en <= 1'b0;
        else     prev_en <= enable;
    end

    assert_h_step_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && prev_en && h_cnt < h_total_last) |=> (h_cnt == $past(h_cnt) + W'(1)));

    assert_h_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && prev_en && h_cnt >= h_total_last) |=> (h_cnt == '0));

    assert_v_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && prev_en && h_cnt < h_total_last) |=> $stable(v_cnt));

    assert_v_step_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && prev_en && h_cnt >= h_total_last && v_cnt < v_total_last)
        |=> (v_cnt == $past(v_cnt) + W'(1)));

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (h_cnt == '0 && v_cnt == '0 && !vblank));

    assert_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        vblank |=> !vblank);

endmodule

bind lcd_sync_gen lcd_sync_checker #(.W(W)) u_sync_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .h_cnt        (h_cnt),
    .v_cnt        (v_cnt),
    .h_total_last (h_total_last),
    .v_total_last (v_total_last),
    .vblank       (vblank)
);

// File: tb/test_lcd_sync_gen.sv
`timescale 1ns/1ps
module test_lcd_sync_gen;

    localparam int W = 12;

    logic clk = 1'b0;
    logic rst, enable, hs_hi, vs_hi, de_hi, prise, layer;
    logic [W-1:0] hsl, hpl, hal, htl, vsl, vpl, val, vtl;
    logic [23:0] bg;
    logic hsync, vsync, de, pclk_fall, vblank;
    logic [W-1:0] h_cnt, v_cnt;
    logic [23:0] rgb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lcd_sync_gen #(.W(W)) i_lcd_sync_gen (
        .clk(clk), .rst(rst), .enable(enable),
        .hs_act_high(hs_hi), .vs_act_high(vs_hi), .de_act_high(de_hi),
        .pclk_rise_sel(prise),
        .h_sync_last(hsl), .h_porch_last(hpl), .h_active_last(hal), .h_total_last(htl),
        .v_sync_last(vsl), .v_porch_last(vpl), .v_active_last(val), .v_total_last(vtl),
        .layer_active(layer), .bg_color(bg),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk_fall(pclk_fall),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .vblank(vblank), .rgb(rgb)
    );

    // Reference raster
    int mh = 0, mv = 0;
    bit mrun = 0;
    logic ehs, evs, ede, evb, epf;
    logic [23:0] ergb;

    function automatic logic lvl(input logic act, input logic hi);
        return hi ? act : !act;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        int nh, nv;
        bit a_hs, a_vs, a_de;
        if (rst) begin
            mh = 0; mv = 0; mrun = 0;
            ehs = !hs_hi; evs = !vs_hi; ede = !de_hi;
            evb = 0; ergb = 0; epf = !prise;
            return;
        end
        if (!enable || !mrun) begin
            nh = 0; nv = 0;
        end else if (mh >= int'(htl)) begin
            nh = 0;
            nv = (mv >= int'(vtl)) ? 0 : mv + 1;
        end else begin
            nh = mh + 1; nv = mv;
        end
        mh = nh; mv = nv; mrun = enable;
        a_hs = enable && nh <= int'(hsl);
        a_vs = enable && nv <= int'(vsl);
        a_de = enable && nh > int'(hpl) && nh <= int'(hal) && nv > int'(vpl) && nv <= int'(val);
        ehs = lvl(a_hs, hs_hi);
        evs = lvl(a_vs, vs_hi);
        ede = lvl(a_de, de_hi);
        evb = enable && nh == 0 && nv == int'(val) + 1;
        ergb = (a_de && !layer) ? bg : 24'h0;
        epf = !prise;
    endtask

    task automatic compare();
        check(h_cnt == W'(mh), "R3", "h_cnt", h_cnt, mh);
        check(v_cnt == W'(mv), "R4", "v_cnt", v_cnt, mv);
        check(hsync == ehs, hs_hi ? "R5" : "R5 R7", "hsync", hsync, ehs);
        check(vsync == evs, vs_hi ? "R5" : "R5 R7", "vsync", vsync, evs);
        check(de == ede, de_hi ? "R6" : "R6 R7", "de", de, ede);
        check(vblank == evb, "R9", "vblank", vblank, evb);
        check(rgb == ergb, "R10", "rgb", rgb, ergb);
        check(pclk_fall == epf, "R8", "pclk_fall", pclk_fall, epf);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        layer = $urandom_range(0, 3) == 0;
    endtask

    task automatic set_cfg(input int hw, input int hb, input int ha, input int hf,
                           input int vw, input int vb, input int va, input int vf);
        hsl = W'(hw - 1);
        hpl = W'(hw + hb - 1);
        hal = W'(hw + hb + ha - 1);
        htl = W'(hw + hb + ha + hf - 1);
        vsl = W'(vw - 1);
        vpl = W'(vw + vb - 1);
        val = W'(vw + vb + va - 1);
        vtl = W'(vw + vb + va + vf - 1);
    endtask

    task automatic run_phase(input int cycles, input bit drop_mid);
        int frame;
        frame = (int'(htl) + 1) * (int'(vtl) + 1);
        enable = 0;
        for (int i = 0; i < 3; i++) begin
            cyc();
            // R2: disabled raster parks at origin with idle outputs
            check(h_cnt == 0 && v_cnt == 0 && vblank == 0 && de == !de_hi,
                  "R2", "idle state", {h_cnt, v_cnt}, 0);
        end
        enable = 1;
        for (int i = 0; i < cycles; i++) begin
            if (drop_mid && i == frame / 2) enable = 0;
            if (drop_mid && i == frame / 2 + 2) enable = 1;
            cyc();
        end
    endtask

    int vb_count;

    initial begin
        void'($urandom(32'd2024));
        rst = 1; enable = 0; layer = 0;
        hs_hi = 1; vs_hi = 1; de_hi = 1; prise = 1;
        bg = 24'h123456;
        set_cfg(2, 2, 6, 2, 1, 1, 4, 1);
        cyc();
        cyc();
        // R1: reset state
        check(h_cnt == 0 && v_cnt == 0, "R1", "counters in reset", {h_cnt, v_cnt}, 0);
        check(hsync == 0 && vsync == 0 && de == 0, "R1", "sync levels in reset",
              {hsync, vsync, de}, 0);
        check(vblank == 0 && rgb == 0, "R1", "vblank/rgb in reset", rgb, 0);
        rst = 0;
        cyc();
        check(h_cnt == 0 && rgb == 0, "R1", "first cycle after reset", rgb, 0);

        // Directed: all polarities high, count vblank pulses over two frames
        vb_count = 0;
        enable = 1;
        cyc();
        check(h_cnt == 0 && v_cnt == 0, "R3", "origin on first enabled cycle",
              {h_cnt, v_cnt}, 0);
        for (int i = 0; i < 2 * 12 * 7; i++) begin
            cyc();
            if (vblank) vb_count++;
        end
        check(vb_count == 2, "R9", "vblank pulses in two frames", vb_count, 2);

        // Directed: all polarities low, falling edge launch
        hs_hi = 0; vs_hi = 0; de_hi = 0; prise = 0;
        run_phase(200, 0);
        check(pclk_fall == 1, "R8", "falling edge select", pclk_fall, 1);

        // Directed: every region one wide
        hs_hi = 1; vs_hi = 0; de_hi = 1; prise = 1;
        bg = 24'hFF00A5;
        set_cfg(1, 1, 1, 1, 1, 1, 1, 1);
        run_phase(64, 1);

        // Random timing sets
        for (int p = 0; p < 8; p++) begin
            set_cfg($urandom_range(1, 3), $urandom_range(1, 3), $urandom_range(1, 8),
                    $urandom_range(1, 3), $urandom_range(1, 3), $urandom_range(1, 3),
                    $urandom_range(1, 8), $urandom_range(1, 3));
            hs_hi = $urandom_range(0, 1);
            vs_hi = $urandom_range(0, 1);
            de_hi = $urandom_range(0, 1);
            prise = $urandom_range(0, 1);
            bg = 24'($urandom);
            run_phase((int'(htl) + 1) * (int'(vtl) + 1) * 2 + $urandom_range(0, 20), p[0]);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule